// File: doc/BRIEF.md
# SPI Byte Master with Status Register

This block is a serial peripheral interface master that hangs off an 8-bit synchronous register bus. Software sets up clock polarity, clock phase and a clock rate in a control register. Writing a byte to the data register starts a full-duplex exchange. One shift register sends the byte out on MOSI, most significant bit first, and collects the byte that comes back on MISO.

When the eighth bit completes, the received byte moves into a separate read buffer and a completion flag is raised. The transmit side has no buffer. While the completion flag is still pending, further data writes are refused and recorded as collisions. If a second transfer finishes before software has consumed the first result, an overrun is recorded instead.

A slave-select input, or a software stand-in for it, is watched for a mode fault. A mode fault shuts the master down. An interrupt line combines completion and mode fault under an enable bit.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the data, control and status registers all read 0x00, and `sck`, `irq` and `mosi_oe` are 0.
- R2: The data register is at bus offset 1, control at offset 2 and status at offset 3, and offset 0 reads 0x00. Control bits, from 7 down to 0, are: irq_en, enable, rate2, master, cpol, cpha, rate1, rate0. Status bits, from 7 down to 0, are: done, collision, overrun, fault, 0, out_dis, sw_sel, sw_sel_val. Only status bits 2..0 are writable.
- R3: With enable=1 and master=1, a data write that is accepted shifts the byte out on MOSI, MSB first, over exactly 8 SCK pulses, and captures 8 bits from MISO.
- R4: SCK idles at cpol. With cpha=0, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With cpha=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: The SCK period is 2^(code+1) bus clock cycles, where code = {rate2, rate1, rate0}.
- R6: At the end of a transfer the done flag is set. The received byte is copied into the read buffer in the same cycle, and data-register reads return that buffer.
- R7: A data write is ignored and sets the collision flag in two cases: while a transfer is running, and while the done flag is set with no status read since it was set.
- R8: A status read that sees done=1, followed by a data-register read, clears the done, collision and overrun flags.
- R9: If a transfer completes while done is still set, the overrun flag is set and the read buffer keeps its old byte.
- R10: `irq` is 1 exactly when irq_en=1 and either done or fault is set.
- R11: When enable and master are both 1 and the effective select is low, a mode fault occurs. The effective select is sw_sel_val when sw_sel=1, and otherwise the `ss_n` pin. A mode fault sets the fault flag, clears enable and master, and aborts any transfer so that SCK returns to idle. A status read that sees fault, followed by a control write, clears the fault flag.
- R12: `mosi_oe` is 1 exactly when enable=1, master=1 and out_dis=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and serial logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_re` |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` and `sck` |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select sense pin, active low |

## Verification
A slave model answers every transfer. The bench runs eight transfers that together cover all four polarity/phase pairings and all eight rate codes. The bytes are chosen so that MSB-first order, all-zero and all-one data, and alternating patterns can be told apart. Comparing the captured MOSI byte, the returned MISO byte, the pulse count and the measured SCK period separates a wrong sampling edge from a wrong bit order and from a wrong divider.

Directed cases then cover these conditions:
- a write while a transfer is running;
- a write while done is pending;
- an overrun;
- a mode fault from the software select;
- a mode fault from the pin, including one in the middle of a transfer.

The interrupt line and the output enable are checked along the way.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd3;

    // Control register layout, bit 7 first
    typedef struct packed {
        logic irq_en;
        logic enable;
        logic rate2;
        logic master;
        logic cpol;
        logic cpha;
        logic rate1;
        logic rate0;
    } ctrl_t;

    // Status register layout, bit 7 first
    typedef struct packed {
        logic done;
        logic coll;
        logic ovr;
        logic fault;
        logic rsv;
        logic out_dis;
        logic sw_sel;
        logic sw_sel_val;
    } stat_t;
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    // Half-period length is 2^rate cycles; tick marks each SCK edge
    always_comb begin
        limit = CNT_W'((1 << rate) - 1);
        tick  = run && (cnt_q == limit);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_byte,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [EDGE_W-1:0] edge_idx;
        logic [DATA_W-1:0] shreg;
        logic              tx_bit;
    } core_t;

    core_t state_d, state_q;
    logic  leading, sample_edge;

    always_comb begin
        state_d     = state_q;
        done        = 1'b0;
        leading     = (state_q.phase == 1'b0);
        sample_edge = leading ^ cpha;
        if (abort) begin
            state_d.busy     = 1'b0;
            state_d.phase    = 1'b0;
            state_d.edge_idx = '0;
        end else if (start && !state_q.busy) begin
            state_d.busy     = 1'b1;
            state_d.phase    = 1'b0;
            state_d.edge_idx = '0;
            state_d.shreg    = start_byte;
            state_d.tx_bit   = start_byte[DATA_W-1];
        end else if (state_q.busy && tick) begin
            state_d.phase    = ~state_q.phase;
            state_d.edge_idx = state_q.edge_idx + 1'b1;
            if (sample_edge) state_d.shreg  = {state_q.shreg[DATA_W-2:0], miso};
            else             state_d.tx_bit = state_q.shreg[DATA_W-1];
            if (state_q.edge_idx == EDGE_W'(EDGES - 1)) begin
                state_d.busy = 1'b0;
                done         = 1'b1;
            end
        end
        rx_byte = state_d.shreg;
        sck     = cpol ^ state_q.phase;
        mosi    = state_q.tx_bit;
        busy    = state_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.busy |-> sck == cpol);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    input  logic              ss_n
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              done;
        logic              coll;
        logic              ovr;
        logic              fault;
        logic              seen;
        logic              fault_arm;
        logic              out_dis;
        logic              sw_sel;
        logic              sw_sel_val;
        logic [DATA_W-1:0] rxbuf;
    } regs_t;

    regs_t             state_d, state_q;
    logic              wr_data, rd_data, wr_ctrl, wr_stat, rd_stat;
    logic              sel_eff, fault_cond, blocked, collide, clear_ok;
    logic              core_start, core_busy, core_done, tick;
    logic [DATA_W-1:0] core_rx;
    logic [RATE_W-1:0] rate;
    stat_t             stat_word;

    always_comb begin
        wr_data    = bus_we && bus_addr == OFS_DATA;
        rd_data    = bus_re && bus_addr == OFS_DATA;
        wr_ctrl    = bus_we && bus_addr == OFS_CTRL;
        wr_stat    = bus_we && bus_addr == OFS_STAT;
        rd_stat    = bus_re && bus_addr == OFS_STAT;
        sel_eff    = state_q.sw_sel ? state_q.sw_sel_val : ss_n;
        fault_cond = state_q.ctrl.enable && state_q.ctrl.master && !sel_eff;
        blocked    = state_q.done && !state_q.seen;
        collide    = wr_data && (blocked || core_busy);
        core_start = wr_data && !collide && state_q.ctrl.enable &&
                     state_q.ctrl.master && !fault_cond;
        clear_ok   = rd_data && state_q.seen;
        rate       = {state_q.ctrl.rate2, state_q.ctrl.rate1, state_q.ctrl.rate0};

        state_d = state_q;
        if (wr_ctrl) begin
            state_d.ctrl = ctrl_t'(bus_wdata);
            if (state_q.fault && state_q.fault_arm) begin
                state_d.fault     = 1'b0;
                state_d.fault_arm = 1'b0;
            end
        end
        if (wr_stat) begin
            state_d.out_dis    = bus_wdata[2];
            state_d.sw_sel     = bus_wdata[1];
            state_d.sw_sel_val = bus_wdata[0];
        end
        if (rd_stat && state_q.done)  state_d.seen      = 1'b1;
        if (rd_stat && state_q.fault) state_d.fault_arm = 1'b1;
        if (clear_ok) begin
            state_d.done = 1'b0;
            state_d.coll = 1'b0;
            state_d.ovr  = 1'b0;
            state_d.seen = 1'b0;
        end
        if (collide) state_d.coll = 1'b1;
        if (core_done) begin
            if (state_q.done) state_d.ovr   = 1'b1;
            else              state_d.rxbuf = core_rx;
            state_d.done = 1'b1;
        end
        if (fault_cond) begin
            state_d.fault         = 1'b1;
            state_d.fault_arm     = 1'b0;
            state_d.ctrl.enable   = 1'b0;
            state_d.ctrl.master   = 1'b0;
        end

        stat_word = '{done: state_q.done, coll: state_q.coll, ovr: state_q.ovr,
                      fault: state_q.fault, rsv: 1'b0, out_dis: state_q.out_dis,
                      sw_sel: state_q.sw_sel, sw_sel_val: state_q.sw_sel_val};
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                OFS_DATA: bus_rdata = state_q.rxbuf;
                OFS_CTRL: bus_rdata = state_q.ctrl;
                OFS_STAT: bus_rdata = stat_word;
                default:  bus_rdata = '0;
            endcase
        end
        irq     = state_q.ctrl.irq_en && (state_q.done || state_q.fault);
        mosi_oe = state_q.ctrl.enable && state_q.ctrl.master && !state_q.out_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    spi_clkdiv #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(core_busy), .rate(rate), .tick(tick)
    );

    spi_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(core_start), .start_byte(bus_wdata),
        .abort(fault_cond), .tick(tick), .cpol(state_q.ctrl.cpol),
        .cpha(state_q.ctrl.cpha), .miso(miso), .sck(sck), .mosi(mosi),
        .busy(core_busy), .done(core_done), .rx_byte(core_rx)
    );

    // R6
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> state_q.done);
    // R7
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !bus_re && state_q.done && !state_q.seen) |=> state_q.coll);
    // R9
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && state_q.done && !clear_ok) |=> (state_q.ovr && $stable(state_q.rxbuf)));
    // R11
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> (state_q.fault && !state_q.ctrl.enable && !state_q.ctrl.master && !core_busy));
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    import spi_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic       we = 0, re = 0, irq, sck, mosi, mosi_oe, miso = 0, ss_n = 1;

    int checks = 0, errors = 0;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_re(re), .bus_rdata(rdata), .irq(irq), .sck(sck),
        .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave model: acts one time unit after each rising edge
    logic       m_cpol = 0, m_cpha = 0, arm_req = 0, sck_prev = 0;
    logic [7:0] arm_byte = 0, slv_sr = 0, mosi_cap = 0;
    int         cyc = 0, lead_cnt = 0, last_lead = 0, period = 0;

    always @(posedge clk) begin
        #1;
        cyc++;
        if (arm_req) begin
            arm_req  = 0;
            slv_sr   = arm_byte;
            mosi_cap = 0;
            lead_cnt = 0;
            period   = 0;
            sck_prev = sck;
            if (!m_cpha) begin miso = slv_sr[7]; slv_sr = slv_sr << 1; end
        end else if (sck !== sck_prev) begin
            automatic logic leading = (sck_prev == m_cpol);
            if (leading) begin
                lead_cnt++;
                if (lead_cnt > 1) period = cyc - last_lead;
                last_lead = cyc;
            end
            if (leading ^ m_cpha) mosi_cap = {mosi_cap[6:0], mosi};
            else begin miso = slv_sr[7]; slv_sr = slv_sr << 1; end
            sck_prev = sck;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; re = 1;
        #1 v = rdata;
        @(negedge clk); re = 0;
    endtask

    task automatic start_xfer(input logic [7:0] tx, input logic [7:0] slv);
        @(negedge clk); arm_byte = slv; arm_req = 1; addr = OFS_DATA; wdata = tx; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic wait_done(output logic [7:0] s);
        s = 0;
        for (int i = 0; i < 5000; i++) begin
            rd(OFS_STAT, s);
            if (s[7]) break;
        end
    endtask

    // {cpol, cpha, rate, tx byte, slave byte}
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C}, {1'b0, 1'b1, 3'd1, 8'h81, 8'hFF},
        {1'b1, 1'b0, 3'd2, 8'h00, 8'h96}, {1'b1, 1'b1, 3'd3, 8'h7E, 8'h01},
        {1'b0, 1'b0, 3'd4, 8'hC3, 8'h5A}, {1'b0, 1'b1, 3'd5, 8'h12, 8'hED},
        {1'b1, 1'b0, 3'd6, 8'hFF, 8'h00}, {1'b1, 1'b1, 3'd7, 8'h69, 8'hB4}
    };

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(OFS_CTRL, s); chk("R1 ctrl", s, 0);
        rd(OFS_STAT, s); chk("R1 stat", s, 0);
        rd(OFS_DATA, s); chk("R1 data", s, 0);
        chk("R1 sck", sck, 0); chk("R1 irq", irq, 0); chk("R1 mosi_oe", mosi_oe, 0);

        // R2 map and writable bits, R12 output enable, R10 no irq without flags
        wr(OFS_CTRL, 8'hFF); rd(OFS_CTRL, s); chk("R2 ctrl readback", s, 8'hFF);
        chk("R10 irq idle", irq, 0);
        wr(OFS_STAT, 8'hFF); rd(OFS_STAT, s); chk("R2 stat writable", s, 8'h07);
        rd(2'd0, s); chk("R2 offset0", s, 0);
        chk("R12 out_dis", mosi_oe, 0);
        wr(OFS_STAT, 8'h00); chk("R12 enabled", mosi_oe, 1);

        // R3 R4 R5 R6 R8 vector table
        for (int i = 0; i < 8; i++) begin
            automatic logic [20:0] v = VEC[i];
            automatic int rt = int'(v[18:16]);
            m_cpol = v[20]; m_cpha = v[19];
            wr(OFS_CTRL, {1'b0, 1'b1, v[18], 1'b1, v[20], v[19], v[17], v[16]});
            start_xfer(v[15:8], v[7:0]);
            wait_done(s);
            chk("R6 done status", s, 8'h80);
            chk("R3 mosi byte", mosi_cap, v[15:8]);
            chk("R3 pulse count", lead_cnt, 8);
            chk("R5 sck period", period, 2 << rt);
            chk("R4 sck idle", sck, v[20]);
            rd(OFS_DATA, s); chk("R6 rx byte", s, v[7:0]);
            rd(OFS_STAT, s); chk("R8 cleared", s, 0);
        end

        // R7 blocked while done pending, R10 irq
        m_cpol = 0; m_cpha = 0;
        wr(OFS_CTRL, 8'hD0);
        start_xfer(8'h5A, 8'h33);
        repeat (40) @(negedge clk);
        chk("R10 irq on done", irq, 1);
        wr(OFS_DATA, 8'h11);
        repeat (40) @(negedge clk);
        chk("R7 no new transfer", lead_cnt, 8);
        rd(OFS_STAT, s); chk("R7 collision", s, 8'hC0);
        rd(OFS_DATA, s); chk("R7 buffer", s, 8'h33);
        rd(OFS_STAT, s); chk("R8 clear all", s, 0);
        chk("R10 irq clear", irq, 0);

        // R7 write during transfer
        wr(OFS_CTRL, 8'h53);
        start_xfer(8'hC6, 8'h2D);
        wr(OFS_DATA, 8'h00);
        wait_done(s);
        chk("R7 busy collision", s, 8'hC0);
        chk("R7 tx intact", mosi_cap, 8'hC6);
        rd(OFS_DATA, s); chk("R7 rx intact", s, 8'h2D);

        // R9 overrun
        wr(OFS_CTRL, 8'h50);
        start_xfer(8'h0F, 8'hF0);
        wait_done(s);
        start_xfer(8'hAA, 8'h55);
        repeat (40) @(negedge clk);
        chk("R9 second ran", mosi_cap, 8'hAA);
        rd(OFS_STAT, s); chk("R9 overrun", s, 8'hA0);
        rd(OFS_DATA, s); chk("R9 old byte kept", s, 8'hF0);
        rd(OFS_STAT, s); chk("R8 overrun cleared", s, 0);

        // R11 fault from software select
        wr(OFS_CTRL, 8'hD0);
        wr(OFS_STAT, 8'h02);
        rd(OFS_STAT, s); chk("R11 fault flag", s, 8'h12);
        chk("R10 irq on fault", irq, 1);
        rd(OFS_CTRL, s); chk("R11 ctrl off", s, 8'h80);
        wr(OFS_STAT, 8'h03);
        wr(OFS_CTRL, 8'h50);
        rd(OFS_STAT, s); chk("R11 fault cleared", s, 8'h03);

        // R11 fault from pin, mid-transfer abort
        wr(OFS_STAT, 8'h00);
        wr(OFS_CTRL, 8'h77);
        m_cpol = 0; m_cpha = 1;
        start_xfer(8'h3C, 8'hC3);
        repeat (300) @(negedge clk);
        ss_n = 0;
        repeat (5) @(negedge clk);
        chk("R11 sck idle", sck, 0);
        rd(OFS_CTRL, s); chk("R11 pin fault ctrl", s, 8'h20 | 8'h07);
        ss_n = 1;
        repeat (3000) @(negedge clk);
        rd(OFS_STAT, s); chk("R11 aborted", s, 8'h10);
        chk("R12 off after fault", mosi_oe, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule